// File: doc/BRIEF.md
# Four-Channel Down-Counting PWM Timer Bank

This block holds four independent pulse-width timers behind one small register bus. Each channel runs a down-counter at a tick rate taken from the system clock divided by 2, 4, 8 or 16. The counter is compared against an active compare value to form a PWM waveform, and the channel emits a one-cycle interrupt pulse each time its counter reaches zero. Software never writes the running counter directly. It writes a count buffer and a compare buffer, and those values reach the counter only through a manual transfer or through automatic reload at terminal count.

One shared control word holds four bits per channel: run, manual transfer, output invert and auto-reload. The 4-bit group for channel 0 starts at bit 0. The group for channel n (n ≥ 1) starts at bit 4·n+4, so bits 4 to 7 are unused. A second register holds a 2-bit divider select per channel. Because the counter runs downwards, a duty of d ticks in a period of N+1 ticks is obtained by programming the compare value to d. The output is high while the counter is below the compare value.

Top module: `pwm_timer_bank`

## Requirements
- R1: After synchronous active-low reset, every register reads 0, every live counter reads 0, and `pwm_out` and `tc_irq` are all low.
- R2: Channel n's control group starts at bit 0 for n=0 and at bit 4·n+4 for n≥1. Within the group, +0 is run, +1 is manual transfer, +2 is invert and +3 is auto-reload. Unused control bits read back 0, so writing all ones reads back 0x000FFF0F.
- R3: Writing a count or compare buffer (addresses 2+2n and 3+2n) leaves the live counter of that channel unchanged.
- R4: While the manual-transfer bit is set, the live counter and compare value follow the buffers every cycle and do not count, even with run set. Once the bit clears, the counter counts down.
- R5: With auto-reload set and a count buffer N ≥ 1, the counter reloads both count and compare from the buffers after reaching zero. The interrupt period is then exactly (N+1)·D clock cycles, where D is the divider.
- R6: Without auto-reload, the counter stops at zero and raises exactly one interrupt.
- R7: The prescaler register (address 1) holds channel n's divider select at bits [2n+1:2n]. The codes are 00=/2, 01=/4, 10=/8 and 11=/16, and the counter steps by at most one per tick.
- R8: While the run bit is clear, the counter and compare value hold. Setting run again resumes the countdown.
- R9: The output is high exactly while the live counter is below the live compare value. Per period it is high for min(C, N+1)·D cycles: a compare of 0 gives a constantly low output, and a compare above N gives a constantly high one.
- R10: The invert bit complements the output, giving (N+1)·D − min(C, N+1)·D high cycles per period.
- R11: `tc_irq[n]` is a single-cycle pulse in the cycle the counter first reads zero after counting down from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for `bus_addr`/`bus_wdata` |
| bus_addr | input | 4 | Register address: 0 control, 1 prescaler, 2+2n count buffer, 3+2n compare buffer, 10+n live counter (read only) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 4 | PWM output per channel |
| tc_irq | output | 4 | Terminal-count interrupt pulse per channel |

## Verification
The bench sweeps every channel through all four divider codes and several count/compare pairs. For each it measures the interrupt spacing and the number of high output cycles over one period, with and without inversion. The compare values include 0, values inside the period and values beyond it. A wrong divider tap or an off-by-one reload would give a wrong period. A wrong comparison or a wrong clamp would show as a stray high cycle at 0% or a low cycle at 100%. The bench also checks the following behaviours:
- Buffer writes are confirmed not to move the live counter.
- A held manual-transfer bit is confirmed to freeze counting.
- A one-shot run is confirmed to stop at zero with a single interrupt.
- A misplaced control offset would start the wrong channel, which the bench would see.

// File: rtl/pwmb_pkg.sv
// Package: shared constants and helpers for the PWM timer bank.
// Assumes at most six channels, so the control word fits in 32 bits.
package pwmb_pkg;

    localparam int OFS_RUN    = 0;
    localparam int OFS_MANUAL = 1;
    localparam int OFS_INVERT = 2;
    localparam int OFS_RELOAD = 3;

    // Base bit of a channel's 4-bit control group in the shared word.
    function automatic int ctrl_base(int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    // Mask of the control bits that exist for a given channel count.
    function automatic logic [31:0] ctrl_mask(int nch);
        logic [31:0] m;
        m = '0;
        for (int c = 0; c < nch; c++) begin
            m[ctrl_base(c) +: 4] = 4'hF;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwmb_prescale.sv
// Prescaler: a free-running 4-bit counter whose low bits form tick
// enables at clk/2, /4, /8 and /16. Each channel picks one tap with its
// 2-bit select. Assumes the select is stable during normal running.
module pwmb_prescale #(
    parameter int NCH   = 4,
    parameter int TAPS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0][1:0]       div_sel,
    output logic [NCH-1:0]            tick
);
    logic [TAPS-1:0] pre_q;
    logic [TAPS-1:0] tap;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Tap k fires once every 2^(k+1) cycles.
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign tap[k] = &pre_q[k:0];
    end

    // Per-channel tap selection.
    for (genvar n = 0; n < NCH; n++) begin : g_sel
        assign tick[n] = tap[div_sel[n]];
    end
endmodule

// File: rtl/pwmb_regs.sv
// Register file: the shared control word, the prescaler selects, and the
// per-channel count and compare buffers. It also provides combinational
// read-back of these registers and of the live counters.
// Assumes a single-cycle write strobe.
module pwmb_regs
    import pwmb_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CTRL_W = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NCH-1:0][CNT_W-1:0]    cnt_live,
    output logic [CTRL_W-1:0]            ctrl_q,
    output logic [NCH-1:0][1:0]          div_q,
    output logic [NCH-1:0][CNT_W-1:0]    cbuf_q,
    output logic [NCH-1:0][CNT_W-1:0]    mbuf_q
);
    localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_W'(ctrl_mask(NCH));
    localparam int A_CTRL = 0;
    localparam int A_DIV  = 1;
    localparam int A_BUF0 = 2;
    localparam int A_LIVE = 2 + 2 * NCH;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    // Register writes, decoded by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
            cbuf_q <= '0;
            mbuf_q <= '0;
        end else if (bus_we) begin
            if (int'(bus_addr) == A_CTRL)
                ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_MASK;
            if (int'(bus_addr) == A_DIV)
                div_q <= bus_wdata[2*NCH-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (int'(bus_addr) == A_BUF0 + 2 * n)
                    cbuf_q[n] <= bus_wdata[CNT_W-1:0];
                if (int'(bus_addr) == A_BUF0 + 2 * n + 1)
                    mbuf_q[n] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == A_CTRL) bus_rdata = DATA_W'(ctrl_q);
        if (int'(bus_addr) == A_DIV)  bus_rdata = DATA_W'(div_q);
        for (int n = 0; n < NCH; n++) begin
            if (int'(bus_addr) == A_BUF0 + 2 * n)     bus_rdata = DATA_W'(cbuf_q[n]);
            if (int'(bus_addr) == A_BUF0 + 2 * n + 1) bus_rdata = DATA_W'(mbuf_q[n]);
            if (int'(bus_addr) == A_LIVE + n)         bus_rdata = DATA_W'(cnt_live[n]);
        end
    end
endmodule

// File: rtl/pwmb_channel.sv
// One timer channel: active counter and compare registers, loaded from the
// buffers by manual transfer or by auto-reload at zero. It counts down on
// each tick while running and drives a registered PWM output and a
// terminal-count pulse. Assumes tick pulses are at least two cycles apart.
module pwmb_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             manual,
    input  logic             invert,
    input  logic             reload,
    input  logic [CNT_W-1:0] cbuf,
    input  logic [CNT_W-1:0] mbuf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             pwm_q,
    output logic             irq_q
);
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] cmp_n;
    logic             irq_n;

    // Next-state selection: transfer, count, reload or hold.
    always_comb begin
        cnt_n = cnt_q;
        cmp_n = cmp_q;
        irq_n = 1'b0;
        if (manual) begin
            cnt_n = cbuf;
            cmp_n = mbuf;
        end else if (run && tick) begin
            if (cnt_q != '0) begin
                cnt_n = cnt_q - CNT_W'(1);
                irq_n = (cnt_q == CNT_W'(1));
            end else if (reload) begin
                cnt_n = cbuf;
                cmp_n = mbuf;
            end
        end
    end

    // State and output registers; the output is computed from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
            pwm_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            cmp_q <= cmp_n;
            pwm_q <= (cnt_n < cmp_n) ^ invert;
            irq_q <= irq_n;
        end
    end
endmodule

// File: rtl/pwm_timer_bank.sv
// Top: four PWM timer channels behind one register bus. It unpacks each
// channel's control group from the shared word at base 0, 8, 12, 16, ...
// Assumes NCH <= 6 and CNT_W <= DATA_W.
module pwm_timer_bank
    import pwmb_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(2 + 3 * NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    tc_irq
);
    localparam int CTRL_W = ctrl_base(NCH - 1) + 4;

    logic [CTRL_W-1:0]         ctrl_q;
    logic [NCH-1:0][1:0]       div_q;
    logic [NCH-1:0][CNT_W-1:0] cbuf_q;
    logic [NCH-1:0][CNT_W-1:0] mbuf_q;
    logic [NCH-1:0][CNT_W-1:0] cnt_live;
    logic [NCH-1:0][CNT_W-1:0] cmp_live;
    logic [NCH-1:0]            tick;
    logic [NCH-1:0]            ch_run;
    logic [NCH-1:0]            ch_man;
    logic [NCH-1:0]            ch_inv;
    logic [NCH-1:0]            ch_rld;
    logic                      unused_ctrl;

    assign unused_ctrl = ^ctrl_q;

    pwmb_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_live(cnt_live),
        .ctrl_q(ctrl_q), .div_q(div_q), .cbuf_q(cbuf_q), .mbuf_q(mbuf_q)
    );

    pwmb_prescale #(.NCH(NCH)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_sel(div_q), .tick(tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int B = ctrl_base(g);
        assign ch_run[g] = ctrl_q[B + OFS_RUN];
        assign ch_man[g] = ctrl_q[B + OFS_MANUAL];
        assign ch_inv[g] = ctrl_q[B + OFS_INVERT];
        assign ch_rld[g] = ctrl_q[B + OFS_RELOAD];

        pwmb_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick[g]),
            .run(ch_run[g]), .manual(ch_man[g]), .invert(ch_inv[g]),
            .reload(ch_rld[g]), .cbuf(cbuf_q[g]), .mbuf(mbuf_q[g]),
            .cnt_q(cnt_live[g]), .cmp_q(cmp_live[g]),
            .pwm_q(pwm_out[g]), .irq_q(tc_irq[g])
        );
    end
endmodule

// File: rtl/pwmb_checker.sv
// Checker: temporal properties of every channel, bound into the top.
module pwmb_checker #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            ch_run,
    input logic [NCH-1:0]            ch_man,
    input logic [NCH-1:0]            ch_inv,
    input logic [NCH-1:0]            ch_rld,
    input logic [NCH-1:0][CNT_W-1:0] cbuf_q,
    input logic [NCH-1:0][CNT_W-1:0] mbuf_q,
    input logic [NCH-1:0][CNT_W-1:0] cnt_live,
    input logic [NCH-1:0][CNT_W-1:0] cmp_live,
    input logic [NCH-1:0]            pwm_out,
    input logic [NCH-1:0]            tc_irq
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_manual_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_man[i] |=> (cnt_live[i] == $past(cbuf_q[i]) && cmp_live[i] == $past(mbuf_q[i])));

        assert_hold_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_run[i] && !ch_man[i]) |=> ($stable(cnt_live[i]) && $stable(cmp_live[i])));

        assert_stop_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_live[i] == '0 && !ch_rld[i] && !ch_man[i]) |=> (cnt_live[i] == '0));

        assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_man[i] && cnt_live[i] != '0) |=>
            (cnt_live[i] == $past(cnt_live[i]) || cnt_live[i] == $past(cnt_live[i]) - CNT_W'(1)));

        assert_output_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_out[i] == ((cnt_live[i] < cmp_live[i]) ^ $past(ch_inv[i])));

        assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
            tc_irq[i] |=> !tc_irq[i]);

        assert_irq_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
            tc_irq[i] |-> (cnt_live[i] == '0 && $past(cnt_live[i]) == CNT_W'(1)));
    end
endmodule

bind pwm_timer_bank pwmb_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ch_run(ch_run), .ch_man(ch_man),
    .ch_inv(ch_inv), .ch_rld(ch_rld), .cbuf_q(cbuf_q), .mbuf_q(mbuf_q),
    .cnt_live(cnt_live), .cmp_live(cmp_live), .pwm_out(pwm_out),
    .tc_irq(tc_irq)
);

// File: tb/tb_pwm_timer_bank.sv
`timescale 1ns/1ps
module tb_pwm_timer_bank;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    logic [3:0]  tc_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_timer_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .tc_irq(tc_irq)
    );

    function automatic int base_of(int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    function automatic logic [31:0] cbits(int ch, bit run, bit man, bit inv, bit rld);
        int b;
        b = base_of(ch);
        return (32'(run) << b) | (32'(man) << (b + 1)) |
               (32'(inv) << (b + 2)) | (32'(rld) << (b + 3));
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wr(int addr, logic [31:0] data);
        step();
        bus_we = 1'b1;
        bus_addr = 4'(addr);
        bus_wdata = data;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(int addr, output logic [31:0] data);
        bus_addr = 4'(addr);
        #0.5;
        data = bus_rdata;
    endtask

    // Run one configuration and measure one full period from an interrupt.
    task automatic run_cfg(int ch, int dcode, int n, int c, bit inv);
        int per;
        int hi;
        int to;
        int div;
        int exp_hi;
        div = 2 << dcode;
        wr(1, 32'(dcode) << (2 * ch));
        wr(2 + 2 * ch, 32'(n));
        wr(3 + 2 * ch, 32'(c));
        wr(0, cbits(ch, 0, 1, inv, 1));
        wr(0, cbits(ch, 1, 0, inv, 1));
        to = 0;
        while (tc_irq[ch] !== 1'b1 && to < 4000) begin
            step();
            to++;
        end
        per = 0;
        hi = 0;
        forever begin
            hi += int'(pwm_out[ch]);
            per++;
            step();
            if (per == 1) check("R11 irq width", int'(tc_irq[ch]), 0);
            if (tc_irq[ch] === 1'b1 || per > 4000) break;
        end
        exp_hi = ((c < n + 1) ? c : n + 1) * div;
        if (inv) exp_hi = (n + 1) * div - exp_hi;
        check($sformatf("R5/R7 period ch%0d div%0d", ch, div), per, (n + 1) * div);
        check($sformatf("%s high ch%0d n%0d c%0d", inv ? "R10" : "R9", ch, n, c), hi, exp_hi);
        wr(0, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] w;
        int cnt;
        repeat (3) step();
        // R1 reset state
        check("R1 pwm_out", int'(pwm_out), 0);
        check("R1 tc_irq", int'(tc_irq), 0);
        for (int a = 0; a < 14; a++) begin
            rd(a, v);
            check($sformatf("R1 reg %0d", a), int'(v), 0);
        end
        rst_n = 1'b1;
        step();

        // R2 control mask and bit positions
        wr(0, 32'hFFFF_FFFF);
        rd(0, v);
        check("R2 ctrl readback", int'(v), 32'h000F_FF0F);
        wr(0, 32'h0);
        wr(4, 32'd30);
        wr(0, 32'h0000_0200);
        wr(0, 32'h0000_0100);
        repeat (20) step();
        rd(11, v);
        check("R2 ch1 counting", int'(v < 30 && v > 15), 1);
        rd(10, v);
        check("R2 ch0 untouched", int'(v), 0);
        wr(0, 32'h0);

        // R7 prescaler field positions
        wr(1, 32'hE4);
        rd(1, v);
        check("R7 prescaler readback", int'(v), 32'hE4);
        wr(1, 32'h0);

        // R4 manual transfer holds counting
        wr(2, 32'd50);
        wr(3, 32'd10);
        wr(0, cbits(0, 1, 1, 0, 0));
        repeat (20) step();
        rd(10, v);
        check("R4 held during manual", int'(v), 50);
        wr(0, cbits(0, 1, 0, 0, 0));
        repeat (20) step();
        rd(10, v);
        check("R4 counts after manual", int'(v < 50), 1);

        // R3 buffer write leaves live counter alone
        wr(0, 32'h0);
        rd(10, v);
        wr(2, 32'd7);
        wr(3, 32'd3);
        rd(10, w);
        check("R3 live after buffer write", int'(w), int'(v));

        // R6 one-shot stops at zero with one interrupt
        wr(1, 32'h0);
        wr(6, 32'd3);
        wr(7, 32'd1);
        wr(0, cbits(2, 0, 1, 0, 0));
        wr(0, cbits(2, 1, 0, 0, 0));
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            cnt += int'(tc_irq[2]);
            step();
        end
        check("R6 single irq", cnt, 1);
        rd(12, v);
        check("R6 stopped at zero", int'(v), 0);
        wr(0, 32'h0);

        // R8 halt and resume
        wr(8, 32'd200);
        wr(0, cbits(3, 0, 1, 0, 1));
        wr(0, cbits(3, 1, 0, 0, 1));
        repeat (20) step();
        wr(0, cbits(3, 0, 0, 0, 1));
        rd(13, v);
        repeat (30) step();
        rd(13, w);
        check("R8 halted", int'(w), int'(v));
        wr(0, cbits(3, 1, 0, 0, 1));
        repeat (10) step();
        rd(13, w);
        check("R8 resumed", int'(w < v), 1);
        wr(0, 32'h0);

        // R5/R7/R9/R10 sweep over channels, dividers and compare values
        for (int ch = 0; ch < NCH; ch++) begin
            for (int d = 0; d < 4; d++) begin
                run_cfg(ch, d, 3, 2, 0);
                run_cfg(ch, d, 4, 0, 0);
                run_cfg(ch, d, 2, 6, 0);
                run_cfg(ch, d, 5, 5, 1);
            end
        end
        run_cfg(1, 1, 3, 0, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule